// File: doc/BRIEF.md
# Parallel Flash Identification Probe

This block works out which command-unlock addressing a parallel NOR-style flash accepts. After a start pulse it drives a fixed series of byte transfers over a simple request/acknowledge bus. It returns the flash to read-array mode, issues an unlock-and-identify command with the first address pair, reads three identification bytes, and returns the flash to read-array mode again. It then looks the bytes up in a parameter table.

If the first lookup finds no entry, it runs the same series with the second address pair and looks in a second table. The first table is keyed on the manufacturer byte and the third identification byte. The second table is keyed on the manufacturer byte and the device byte.

The result is one of three outcomes: method A, method B, or an identification failure. With method A or B the block also reports the three bytes it read. A width input selects the read stride, so byte-wide and word-wide parts are probed at the right offsets. System code starts the probe once and then uses the reported method for its later program and erase sequences.

Top module: `flid_probe`

## Requirements
- R1: After reset the outputs read as follows: busy=0, done=0, method=2'b00 (unknown), fail=0, all three ID bytes 0x00, bus_req=0.
- R2: A start pulse while idle clears method to 2'b00, fail to 0 and the ID bytes to 0x00, then raises busy until the result is posted. A start pulse while busy is ignored: the transfer series and the result are unchanged.
- R3: A transfer is offered with bus_req=1 and is held with stable bus_we, bus_addr and bus_wdata until bus_ack=1. Each cycle with bus_req=1 and bus_ack=1 completes exactly one transfer. Read data is taken from bus_rdata in that cycle.
- R4: The first pass is eight transfers, in this order: write 0xF0 to offset 0x000; write 0xAA to 0xAAA; write 0x55 to 0x555; write 0x90 to 0xAAA; read offset 0; read offset s; read offset 2s; write 0xF0 to offset 0x000.
- R5: The stride s is 2 when `wide` is 1 at start and 1 when it is 0. The stride is latched at start.
- R6: If a valid first-table entry equals {manufacturer byte, third byte}, the block posts method=2'b01 and the three bytes, and issues no further transfers (8 in total).
- R7: Otherwise a second pass of eight transfers follows, in this order: write 0xF0 to 0x000; write 0xAA to 0x555; write 0x55 to 0x2AA; write 0x90 to 0x555; reads at 0, s and 2s; write 0xF0 to 0x000 (16 in total).
- R8: If a valid second-table entry equals {manufacturer byte, device byte}, the block posts method=2'b10 and the three bytes read in the second pass.
- R9: If neither pass finds an entry, the block posts fail=1, method=2'b00 and all ID bytes 0x00.
- R10: A table entry whose valid bit is 0 never matches, even when its bytes equal the bytes read.
- R11: done is a single-cycle pulse in the cycle after the last transfer is accepted, and busy is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| wide | input | 1 | 1: word-wide flash, read stride 2; 0: byte-wide, stride 1 |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse when the result is posted |
| method | output | 2 | 00 unknown, 01 method A, 10 method B |
| id_manuf | output | 8 | Manufacturer byte of the identified part |
| id_dev | output | 8 | Device byte of the identified part |
| id_third | output | 8 | Third identification byte of the identified part |
| id_fail | output | 1 | Neither table matched |
| bus_req | output | 1 | Transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Flash byte offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer accepted |

## Verification
The checker watches several properties on every cycle:
- the bus fields stay stable while a request waits for its acknowledge;
- method and fail stay cleared for the whole of a run;
- done only follows an accepted transfer, and comes with busy low;
- every posted result is either a method or a failure, never both;
- a failure always carries zeroed ID bytes.

Other behaviour can only be shown by the bench's directed scenarios, which run against a behavioural flash that enters identify mode only on its own unlock addresses. These scenarios cover the exact order of the transfers, the stride under each width setting, and the choice of table key in each pass. They also cover the fallback when a first-table manufacturer pairs with the wrong third byte, the effect of an invalid table entry, and a start pulse issued mid-run.

// File: rtl/flid_pkg.sv
package flid_pkg;

    localparam int STEP_W   = 4;
    localparam int OFS_W    = 12;
    localparam int PASS_LEN = 8;

    typedef enum logic [1:0] {
        METH_NONE = 2'b00,
        METH_A    = 2'b01,
        METH_B    = 2'b10
    } meth_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] manuf;
        logic [7:0] code;
    } id_entry_t;

    typedef struct packed {
        logic             we;
        logic [OFS_W-1:0] ofs;
        logic [7:0]       wdata;
    } bus_op_t;

    typedef struct packed {
        logic [7:0] manuf;
        logic [7:0] dev;
        logic [7:0] third;
    } id_bytes_t;

    // Transfer for a given step; step[3] selects the second unlock scheme.
    function automatic bus_op_t step_op(input logic [STEP_W-1:0] step, input logic wide);
        logic [OFS_W-1:0] ua, ub, stride;
        bus_op_t op;
        ua     = step[3] ? 12'h555 : 12'hAAA;
        ub     = step[3] ? 12'h2AA : 12'h555;
        stride = wide ? 12'd2 : 12'd1;
        case (step[2:0])
            3'd1:    op = '{we: 1'b1, ofs: ua, wdata: 8'hAA};
            3'd2:    op = '{we: 1'b1, ofs: ub, wdata: 8'h55};
            3'd3:    op = '{we: 1'b1, ofs: ua, wdata: 8'h90};
            3'd4:    op = '{we: 1'b0, ofs: '0, wdata: 8'h00};
            3'd5:    op = '{we: 1'b0, ofs: stride, wdata: 8'h00};
            3'd6:    op = '{we: 1'b0, ofs: stride << 1, wdata: 8'h00};
            default: op = '{we: 1'b1, ofs: '0, wdata: 8'hF0};
        endcase
        return op;
    endfunction

endpackage

// File: rtl/flid_match.sv
module flid_match #(
    parameter int N = 4,
    parameter flid_pkg::id_entry_t [N-1:0] TBL = '0
) (
    input  logic [7:0] manuf,
    input  logic [7:0] code,
    output logic       hit
);
    logic [N-1:0] hit_v;

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign hit_v[i] = TBL[i].vld && (TBL[i].manuf == manuf) && (TBL[i].code == code);
    end

    assign hit = |hit_v;
endmodule

// File: rtl/flid_seq.sv
module flid_seq #(
    parameter int AW = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        launch,
    input  logic                        wide,
    input  logic                        finish,
    input  logic                        bus_ack,
    output logic                        busy,
    output logic                        xfer,
    output logic [flid_pkg::STEP_W-1:0] step,
    output logic                        bus_req,
    output logic                        bus_we,
    output logic [AW-1:0]               bus_addr,
    output logic [7:0]                  bus_wdata
);
    import flid_pkg::*;

    logic    wide_q;
    bus_op_t op;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            step   <= '0;
            wide_q <= 1'b0;
        end else if (launch) begin
            busy   <= 1'b1;
            step   <= '0;
            wide_q <= wide;
        end else if (xfer) begin
            if (finish) busy <= 1'b0;
            else        step <= step + 1'b1;
        end
    end

    always_comb op = step_op(step, wide_q);

    assign bus_req   = busy;
    assign bus_we    = op.we;
    assign bus_addr  = AW'(op.ofs);
    assign bus_wdata = op.wdata;
    assign xfer      = busy && bus_ack;
endmodule

// File: rtl/flid_probe.sv
module flid_probe #(
    parameter int AW  = 16,
    parameter int N_A = 4,
    parameter int N_B = 3,
    parameter flid_pkg::id_entry_t [N_A-1:0] TBL_A = '{
        '{1'b1, 8'h01, 8'hDA}, '{1'b1, 8'h20, 8'hD7},
        '{1'b1, 8'h04, 8'hCA}, '{1'b1, 8'hC2, 8'hDA}},
    parameter flid_pkg::id_entry_t [N_B-1:0] TBL_B = '{
        '{1'b1, 8'h01, 8'h3E}, '{1'b1, 8'h20, 8'hAA}, '{1'b1, 8'h89, 8'hA2}}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          wide,
    output logic          busy,
    output logic          done,
    output logic [1:0]    method,
    output logic [7:0]    id_manuf,
    output logic [7:0]    id_dev,
    output logic [7:0]    id_third,
    output logic          id_fail,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    input  logic          bus_ack
);
    import flid_pkg::*;

    localparam logic [STEP_W-1:0] LAST_A = STEP_W'(PASS_LEN - 1);
    localparam logic [STEP_W-1:0] LAST_B = STEP_W'(2 * PASS_LEN - 1);

    logic              launch, xfer, finish, hit_a, hit_b;
    logic [STEP_W-1:0] step;
    id_bytes_t         cap, res_ids;
    meth_e             res_meth;

    assign launch = start && !busy;
    assign finish = xfer && ((step == LAST_A && hit_a) || step == LAST_B);

    flid_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .wide(wide), .finish(finish),
        .bus_ack(bus_ack), .busy(busy), .xfer(xfer), .step(step),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    flid_match #(.N(N_A), .TBL(TBL_A)) u_match_a (
        .manuf(cap.manuf), .code(cap.third), .hit(hit_a));

    flid_match #(.N(N_B), .TBL(TBL_B)) u_match_b (
        .manuf(cap.manuf), .code(cap.dev), .hit(hit_b));

    // Capture identification bytes as each read completes
    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (xfer && !bus_we) begin
            case (step[2:0])
                3'd4:    cap.manuf <= bus_rdata;
                3'd5:    cap.dev   <= bus_rdata;
                3'd6:    cap.third <= bus_rdata;
                default: ;
            endcase
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_meth <= METH_NONE;
            res_ids  <= '0;
            id_fail  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                res_meth <= METH_NONE;
                res_ids  <= '0;
                id_fail  <= 1'b0;
            end else if (finish) begin
                done <= 1'b1;
                if (step == LAST_A) begin
                    res_meth <= METH_A;
                    res_ids  <= cap;
                end else if (hit_b) begin
                    res_meth <= METH_B;
                    res_ids  <= cap;
                end else begin
                    id_fail  <= 1'b1;
                end
            end
        end
    end

    assign method   = res_meth;
    assign id_manuf = res_ids.manuf;
    assign id_dev   = res_ids.dev;
    assign id_third = res_ids.third;
endmodule

// File: rtl/flid_probe_chk.sv
module flid_probe_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic [1:0]    method,
    input logic [7:0]    id_manuf,
    input logic [7:0]    id_dev,
    input logic [7:0]    id_third,
    input logic          id_fail,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_ack
);
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    a_r2_cleared_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (method == 2'b00 && !id_fail));

    a_r11_done_after_xfer: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(bus_req && bus_ack)));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done |-> ((method != 2'b00) != id_fail));

    a_r9_fail_zero_ids: assert property (@(posedge clk) disable iff (rst)
        id_fail |-> (method == 2'b00 && id_manuf == 8'h00 && id_dev == 8'h00 && id_third == 8'h00));
endmodule

bind flid_probe flid_probe_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .method(method),
    .id_manuf(id_manuf), .id_dev(id_dev), .id_third(id_third), .id_fail(id_fail),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack)
);

// File: tb/test_flid_probe.sv
`timescale 1ns/1ps
module test_flid_probe;
    import flid_pkg::*;

    localparam int AW = 16;
    localparam id_entry_t [3:0] T_A = '{
        '{1'b1, 8'h01, 8'hDA}, '{1'b1, 8'h20, 8'hD7},
        '{1'b0, 8'h37, 8'h5C}, '{1'b1, 8'h04, 8'hCA}};
    localparam id_entry_t [2:0] T_B = '{
        '{1'b1, 8'h20, 8'hAA}, '{1'b1, 8'h04, 8'h3E}, '{1'b1, 8'h89, 8'hA2}};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, wide = 1'b0;
    logic busy, done, id_fail, bus_req, bus_we;
    logic [1:0] method;
    logic [7:0] id_manuf, id_dev, id_third, bus_wdata;
    logic [7:0] bus_rdata = 8'hFF;
    logic bus_ack = 1'b0;
    logic [AW-1:0] bus_addr;

    always #4 clk = ~clk;

    flid_probe #(.AW(AW), .N_A(4), .N_B(3), .TBL_A(T_A), .TBL_B(T_B)) i_flid_probe (
        .clk(clk), .rst(rst), .start(start), .wide(wide), .busy(busy), .done(done),
        .method(method), .id_manuf(id_manuf), .id_dev(id_dev), .id_third(id_third),
        .id_fail(id_fail), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

    int n_cmp = 0, n_bad = 0, cyc = 0;

    // Behavioural flash: bit0 of chip_kind answers scheme A, bit1 answers scheme B
    logic [1:0] chip_kind = 2'b01;
    logic [7:0] c_m, c_d, c_t;
    logic       c_wide = 1'b0;
    int  seq_a = 0, seq_b = 0;
    bit  ident = 0;
    int  log_n = 0;
    logic        log_we [64];
    logic [AW-1:0] log_ad [64];
    logic [7:0]  log_wd [64];

    function automatic int adv(int s, logic [AW-1:0] a, logic [7:0] d, logic [AW-1:0] u1, logic [AW-1:0] u2);
        if (s == 0 && d == 8'hAA && a == u1) return 1;
        if (s == 1 && d == 8'h55 && a == u2) return 2;
        if (s == 2 && d == 8'h90 && a == u1) return 3;
        return 0;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req) begin
            if (log_n < 64) begin
                log_we[log_n] = bus_we; log_ad[log_n] = bus_addr; log_wd[log_n] = bus_wdata;
            end
            log_n++;
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (bus_wdata == 8'hF0) begin
                    ident = 0; seq_a = 0; seq_b = 0;
                end else begin
                    seq_a = adv(seq_a, bus_addr, bus_wdata, 16'hAAA, 16'h555);
                    seq_b = adv(seq_b, bus_addr, bus_wdata, 16'h555, 16'h2AA);
                    if ((seq_a == 3 && chip_kind[0]) || (seq_b == 3 && chip_kind[1])) ident = 1;
                end
            end else begin
                int st;
                st = c_wide ? 2 : 1;
                if (!ident)                  bus_rdata <= 8'hFF;
                else if (bus_addr == 0)      bus_rdata <= c_m;
                else if (bus_addr == st)     bus_rdata <= c_d;
                else if (bus_addr == 2 * st) bus_rdata <= c_t;
                else                         bus_rdata <= 8'hFF;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic set_chip(input logic [1:0] k, input logic [7:0] m, d, t, input logic w);
        chip_kind = k; c_m = m; c_d = d; c_t = t; c_wide = w; wide = w;
    endtask

    // Start a probe, optionally pulse start again mid-run, wait for done
    task automatic run_probe(input bool_extra);
        int n;
        @(negedge clk);
        log_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 method cleared", {method, id_fail, id_manuf}, 0);
        if (bool_extra) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R11 done seen", done, 1);
        chk("R11 busy low at done", busy, 0);
        @(negedge clk);
        chk("R11 done single pulse", done, 0);
    endtask

    // Compare the logged transfers with the required series
    task automatic check_series(input int total, input logic w);
        logic [AW-1:0] st, ua, ub, ea;
        logic          ew;
        logic [7:0]    ed;
        string         tg;
        st = w ? 2 : 1;
        chk("R6 R7 transfer count", log_n, total);
        for (int k = 0; k < total && k < log_n; k++) begin
            ua = (k >= 8) ? 16'h555 : 16'hAAA;
            ub = (k >= 8) ? 16'h2AA : 16'h555;
            tg = (k >= 8) ? "R7 series" : "R4 series";
            case (k % 8)
                1: begin ew = 1; ea = ua; ed = 8'hAA; end
                2: begin ew = 1; ea = ub; ed = 8'h55; end
                3: begin ew = 1; ea = ua; ed = 8'h90; end
                4: begin ew = 0; ea = 0;      ed = 0; end
                5: begin ew = 0; ea = st;     ed = 0; end
                6: begin ew = 0; ea = 2 * st; ed = 0; end
                default: begin ew = 1; ea = 0; ed = 8'hF0; end
            endcase
            chk(tg, log_we[k], ew);
            if ((k % 8) >= 4 && (k % 8) <= 6) chk("R5 read offset", log_ad[k], ea);
            else chk(tg, log_ad[k], ea);
            if (ew) chk(tg, log_wd[k], ed);
        end
    endtask

    task automatic check_result(input string tg, input logic [1:0] m, input logic f,
                                input logic [7:0] a, b, c);
        chk({tg, " method"}, method, m);
        chk({tg, " fail"}, id_fail, f);
        chk({tg, " ids"}, {id_manuf, id_dev, id_third}, {a, b, c});
    endtask

    task automatic t_reset_state();
        chk("R1 reset outputs", {busy, done, method, id_fail, bus_req}, 0);
        chk("R1 reset ids", {id_manuf, id_dev, id_third}, 0);
    endtask

    task automatic t_a_byte();
        set_chip(2'b01, 8'h01, 8'h22, 8'hDA, 1'b0);
        run_probe(0);
        check_series(8, 1'b0);
        check_result("R6 byte", 2'b01, 1'b0, 8'h01, 8'h22, 8'hDA);
    endtask

    task automatic t_a_wide();
        set_chip(2'b01, 8'h20, 8'h5B, 8'hD7, 1'b1);
        run_probe(0);
        check_series(8, 1'b1);
        check_result("R6 R5 wide", 2'b01, 1'b0, 8'h20, 8'h5B, 8'hD7);
    endtask

    task automatic t_b_byte();
        set_chip(2'b10, 8'h89, 8'hA2, 8'h11, 1'b0);
        run_probe(0);
        check_series(16, 1'b0);
        check_result("R8 byte", 2'b10, 1'b0, 8'h89, 8'hA2, 8'h11);
    endtask

    task automatic t_key_choice();
        // third byte does not pair with 04 in the first table; device 3E does in the second
        set_chip(2'b11, 8'h04, 8'h3E, 8'h77, 1'b1);
        run_probe(0);
        check_series(16, 1'b1);
        check_result("R8 R7 key choice", 2'b10, 1'b0, 8'h04, 8'h3E, 8'h77);
    endtask

    task automatic t_invalid_entry();
        set_chip(2'b01, 8'h37, 8'h00, 8'h5C, 1'b0);
        run_probe(0);
        check_series(16, 1'b0);
        check_result("R10 invalid entry", 2'b00, 1'b1, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_unknown();
        set_chip(2'b10, 8'h55, 8'hAA, 8'h00, 1'b0);
        run_probe(0);
        check_series(16, 1'b0);
        check_result("R9 unknown", 2'b00, 1'b1, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_start_ignored();
        set_chip(2'b01, 8'h01, 8'h33, 8'hDA, 1'b0);
        run_probe(1);
        check_series(8, 1'b0);
        check_result("R2 start ignored", 2'b01, 1'b0, 8'h01, 8'h33, 8'hDA);
    endtask

    initial begin
        c_m = 0; c_d = 0; c_t = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_a_byte();
        t_a_wide();
        t_b_byte();
        t_key_choice();
        t_invalid_entry();
        t_unknown();
        t_start_ignored();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule